// File: doc/BRIEF.md
# Two-Way Protected Address Translation Buffer

The block caches page translations for a 40-bit virtual and 36-bit physical address space with 16 KB pages. A lookup presents a virtual address together with its direction (read or write) and privilege (user or kernel). One cycle later the block reports exactly one outcome: a hit with the translated physical address, a miss (no valid translation held, so the caller must walk the page table and install one), or a protection fault (a translation exists but the access is not allowed). Each stored translation carries a dirty flag and a two-bit access code; a permitted write marks the translation dirty.

Translations are installed or removed through a refill port that only acts when it is driven in kernel mode. The 256 entries form 128 sets of two ways; within a set the block picks where a refill lands (a way already holding the same page, else an empty way, else the least recently used way). A global flush input empties the whole buffer in one cycle.

The response path is a small state machine with states RS_IDLE, RS_HIT, RS_MISS and RS_FAULT. Every cycle it moves to RS_IDLE when no lookup is presented, to RS_MISS when no valid way of the indexed set holds the tag, to RS_FAULT when a way matches but the access code denies the access, and to RS_HIT otherwise. The outputs are decoded from the current state.

Top module: `tlb_prot`

## Requirements
- R1: The virtual address splits into page offset [13:0], set index [20:14] and tag [39:21]; the fill port's 26-bit page number is {tag, index}. On a hit the physical address is {stored 22-bit page number, virtual address [13:0]}.
- R2: A lookup presented on a clock edge produces, on the next cycle, rsp_valid high with exactly one of rsp_hit, rsp_miss, rsp_fault high; without a lookup rsp_valid and all three flags are low.
- R3: A lookup whose tag matches no valid way of its set reports a miss; rsp_pa is zero on a miss or a fault.
- R4: Access codes: 00 no user access, 01 kernel only, 10 user read-only, 11 user read/write. A user read of code 00 or 01, or a user write of code 00, 01 or 10, reports a fault.
- R5: A kernel-mode lookup that matches a valid way is always a hit, whatever the access code.
- R6: A permitted write hit leaves the entry dirty from the cycle the hit is reported; rsp_dirty gives the entry's dirty flag after the access. A fault never sets the dirty flag.
- R7: The fill port (install or invalidate) changes nothing unless fill_kernel is high.
- R8: An install whose page is already held overwrites that way; otherwise it takes an empty way (way 0 before way 1), else the least recently used way.
- R9: A permitted hit and an install both make the touched way the most recently used of its set; misses and faults leave the order unchanged.
- R10: A kernel invalidate (fill_inval high) removes only the translation for the given page; the other way of the set is kept.
- R11: A flush clears every translation at the next clock edge.
- R12: After reset the buffer holds no translation and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Lookup presented this cycle |
| req_va | input | 40 | Lookup virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| fill_valid | input | 1 | Refill port operation this cycle |
| fill_kernel | input | 1 | Refill issued in kernel mode |
| fill_inval | input | 1 | 1 = invalidate page, 0 = install |
| fill_vpn | input | 26 | Virtual page number to install or remove |
| fill_ppn | input | 22 | Physical page number to install |
| fill_acc | input | 2 | Access code to install |
| fill_dirty | input | 1 | Initial dirty flag to install |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit and permitted |
| rsp_miss | output | 1 | No valid translation |
| rsp_fault | output | 1 | Protection fault |
| rsp_pa | output | 36 | Physical address on a hit, else zero |
| rsp_dirty | output | 1 | Dirty flag of the hit entry after the access |

## Verification
A corrupted valid or tag bit shows on the very next lookup to that page as a miss where a hit was due, or a hit with the wrong physical page. A wrong recency bit stays hidden until the set is full and a third page is installed; the wrong translation is then evicted, which the following lookups of both older pages expose within a few cycles. A dirty flag left clear surfaces in rsp_dirty on the write hit itself and on every later hit of that page, while a permission decode error shows as a fault or hit swapped on the first access of the affected mode and direction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_HIT   = 2'd1,
        RS_MISS  = 2'd2,
        RS_FAULT = 2'd3
    } rsp_state_e;

    localparam logic [1:0] ACC_NONE = 2'b00;
    localparam logic [1:0] ACC_KERN = 2'b01;
    localparam logic [1:0] ACC_URO  = 2'b10;
    localparam logic [1:0] ACC_URW  = 2'b11;

endpackage

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_pkg::*;
(
    input  logic [1:0] acc_i,
    input  logic       kernel_i,
    input  logic       write_i,
    output logic       allow_o
);

    logic user_ok;

    always_comb begin
        unique case (acc_i)
            ACC_NONE: user_ok = 1'b0;
            ACC_KERN: user_ok = 1'b0;
            ACC_URO:  user_ok = !write_i;
            ACC_URW:  user_ok = 1'b1;
            default:  user_ok = 1'b0;
        endcase
        allow_o = kernel_i | user_ok;
    end

    // R5
    always_comb begin
        kern_allow_chk: assert (!(kernel_i === 1'b1) || allow_o);
    end

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int TAG_W = 19,
    parameter int WAYS  = 2
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [WAYS-1:0]            match_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel (
    input  logic [1:0] valid_i,
    input  logic [1:0] match_i,
    input  logic       lru_i,
    output logic       way_o
);

    always_comb begin
        if (|match_i)          way_o = match_i[1];
        else if (!valid_i[0])  way_o = 1'b0;
        else if (!valid_i[1])  way_o = 1'b1;
        else                   way_o = lru_i;
    end

endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
    import tlb_pkg::*;
#(
    parameter int VA_W    = 40,
    parameter int PA_W    = 36,
    parameter int PO_W    = 14,
    parameter int SET_CNT = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic               req_write,
    input  logic               req_kernel,
    input  logic               fill_valid,
    input  logic               fill_kernel,
    input  logic               fill_inval,
    input  logic [VA_W-PO_W-1:0] fill_vpn,
    input  logic [PA_W-PO_W-1:0] fill_ppn,
    input  logic [1:0]         fill_acc,
    input  logic               fill_dirty,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_dirty
);

    localparam int WAYS  = 2;
    localparam int VPN_W = VA_W - PO_W;
    localparam int PPN_W = PA_W - PO_W;
    localparam int IDX_W = $clog2(SET_CNT);
    localparam int TAG_W = VPN_W - IDX_W;

    // Entry storage, one packed pair of ways per set
    logic [WAYS-1:0]            valid_q [SET_CNT];
    logic [WAYS-1:0]            dirty_q [SET_CNT];
    logic [WAYS-1:0][1:0]       acc_q   [SET_CNT];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SET_CNT];
    logic [WAYS-1:0][PPN_W-1:0] ppn_q   [SET_CNT];
    logic                       lru_q   [SET_CNT];

    // Lookup side
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_match;
    logic             lk_any;
    logic             lk_way;
    logic             lk_allow;
    logic             lk_update;

    assign lk_idx = req_va[PO_W +: IDX_W];
    assign lk_tag = req_va[VA_W-1 -: TAG_W];

    tlb_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lk_match (
        .valid_i (valid_q[lk_idx]),
        .tags_i  (tag_q[lk_idx]),
        .tag_i   (lk_tag),
        .match_o (lk_match)
    );

    assign lk_any = |lk_match;
    assign lk_way = lk_match[1];

    tlb_perm_check u_perm (
        .acc_i    (acc_q[lk_idx][lk_way]),
        .kernel_i (req_kernel),
        .write_i  (req_write),
        .allow_o  (lk_allow)
    );

    assign lk_update = req_valid && lk_any && lk_allow;

    // Fill side
    logic [IDX_W-1:0] f_idx;
    logic [TAG_W-1:0] f_tag;
    logic [WAYS-1:0]  f_match;
    logic             f_way;
    logic             f_go;

    assign f_idx = fill_vpn[IDX_W-1:0];
    assign f_tag = fill_vpn[VPN_W-1 -: TAG_W];
    assign f_go  = fill_valid && fill_kernel;

    tlb_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_fill_match (
        .valid_i (valid_q[f_idx]),
        .tags_i  (tag_q[f_idx]),
        .tag_i   (f_tag),
        .match_o (f_match)
    );

    tlb_victim_sel u_victim (
        .valid_i (valid_q[f_idx]),
        .match_i (f_match),
        .lru_i   (lru_q[f_idx]),
        .way_o   (f_way)
    );

    // Entry array update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SET_CNT; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                acc_q[s]   <= '0;
                tag_q[s]   <= '0;
                ppn_q[s]   <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else if (flush) begin
            for (int s = 0; s < SET_CNT; s++) begin
                valid_q[s] <= '0;
            end
        end else begin
            if (lk_update) begin
                lru_q[lk_idx] <= !lk_way;
                if (req_write) begin
                    dirty_q[lk_idx][lk_way] <= 1'b1;
                end
            end
            if (f_go) begin
                if (fill_inval) begin
                    if (|f_match) begin
                        valid_q[f_idx][f_way] <= 1'b0;
                    end
                end else begin
                    valid_q[f_idx][f_way] <= 1'b1;
                    dirty_q[f_idx][f_way] <= fill_dirty;
                    acc_q[f_idx][f_way]   <= fill_acc;
                    tag_q[f_idx][f_way]   <= f_tag;
                    ppn_q[f_idx][f_way]   <= fill_ppn;
                    lru_q[f_idx]          <= !f_way;
                end
            end
        end
    end

    // Response state machine
    rsp_state_e       state_q, state_d;
    logic [PPN_W-1:0] ppn_r;
    logic [PO_W-1:0]  off_r;
    logic             dirty_r;

    always_comb begin
        if (!req_valid)     state_d = RS_IDLE;
        else if (!lk_any)   state_d = RS_MISS;
        else if (!lk_allow) state_d = RS_FAULT;
        else                state_d = RS_HIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            ppn_r   <= '0;
            off_r   <= '0;
            dirty_r <= 1'b0;
        end else begin
            state_q <= state_d;
            ppn_r   <= ppn_q[lk_idx][lk_way];
            off_r   <= req_va[PO_W-1:0];
            dirty_r <= dirty_q[lk_idx][lk_way] | (req_write & lk_allow);
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        rsp_pa    = '0;
        rsp_dirty = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_pa    = {ppn_r, off_r};
                rsp_dirty = dirty_r;
            end
            RS_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            RS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end

    // Flattened valid view for checks
    logic [WAYS*SET_CNT-1:0] valid_all;
    always_comb begin
        for (int s = 0; s < SET_CNT; s++) begin
            valid_all[s*WAYS +: WAYS] = valid_q[s];
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R6
    write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && lk_any && lk_allow) |=> (rsp_hit && rsp_dirty));

    // R7
    user_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_kernel && !flush) |=> $stable(valid_all));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_all == '0));

endmodule

// File: tb/tlb_prot_test.sv
`timescale 1ns/1ps
module tlb_prot_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        req_valid;
    logic [39:0] req_va;
    logic        req_write;
    logic        req_kernel;
    logic        fill_valid;
    logic        fill_kernel;
    logic        fill_inval;
    logic [25:0] fill_vpn;
    logic [21:0] fill_ppn;
    logic [1:0]  fill_acc;
    logic        fill_dirty;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [35:0] rsp_pa;

    int n_tests = 0;
    int n_fail  = 0;

    localparam int K_MISS  = 0;
    localparam int K_HIT   = 1;
    localparam int K_FAULT = 2;

    always #5 clk = ~clk;

    tlb_prot uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .req_kernel(req_kernel),
        .fill_valid(fill_valid), .fill_kernel(fill_kernel), .fill_inval(fill_inval),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_acc(fill_acc),
        .fill_dirty(fill_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty)
    );

    function automatic logic [39:0] mkva(logic [18:0] t, logic [6:0] i, logic [13:0] o);
        return {t, i, o};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lookup(string req, logic [39:0] va, logic wr, logic kern,
                          int kind, logic [21:0] ppn, logic dirty);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_kernel = kern;
        @(negedge clk);
        check({req, " flags"}, {60'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault},
              {60'd0, 1'b1, kind == K_HIT, kind == K_MISS, kind == K_FAULT});
        if (kind == K_HIT) begin
            check({req, " pa"}, rsp_pa, {ppn, va[13:0]});
            check({req, " dirty"}, rsp_dirty, dirty);
        end else begin
            check({req, " pa zero"}, rsp_pa, 0);
        end
        req_valid = 1'b0;
    endtask

    task automatic fill(logic kern, logic inval, logic [18:0] t, logic [6:0] i,
                        logic [21:0] ppn, logic [1:0] acc, logic dirty);
        @(negedge clk);
        fill_valid = 1'b1; fill_kernel = kern; fill_inval = inval;
        fill_vpn = {t, i}; fill_ppn = ppn; fill_acc = acc; fill_dirty = dirty;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 reset rsp_valid", rsp_valid, 0);
        lookup("R12 R3 empty after reset", mkva(19'h1, 7'd5, 14'h10), 0, 1, K_MISS, 0, 0);
    endtask

    task automatic t_basic();
        fill(1, 0, 19'h4_1234, 7'd5, 22'h2A_BCDE, 2'b11, 0);
        lookup("R1 user read hit", mkva(19'h4_1234, 7'd5, 14'h3FFF), 0, 0, K_HIT, 22'h2A_BCDE, 0);
        lookup("R1 top tag bit differs", mkva(19'h0_1234, 7'd5, 14'h0), 0, 0, K_MISS, 0, 0);
        lookup("R1 index differs", mkva(19'h4_1234, 7'd4, 14'h0), 0, 0, K_MISS, 0, 0);
        lookup("R6 user write hit dirty", mkva(19'h4_1234, 7'd5, 14'h0001), 1, 0, K_HIT, 22'h2A_BCDE, 1);
        lookup("R6 dirty kept", mkva(19'h4_1234, 7'd5, 14'h0002), 0, 0, K_HIT, 22'h2A_BCDE, 1);
        // R2 no lookup -> quiet
        @(negedge clk);
        check("R2 quiet", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    endtask

    task automatic t_perm();
        fill(1, 0, 19'h111, 7'd6, 22'h00_0006, 2'b10, 0);
        lookup("R4 ro user read", mkva(19'h111, 7'd6, 14'h5), 0, 0, K_HIT, 22'h6, 0);
        lookup("R4 ro user write fault", mkva(19'h111, 7'd6, 14'h5), 1, 0, K_FAULT, 0, 0);
        lookup("R6 fault left clean", mkva(19'h111, 7'd6, 14'h5), 0, 1, K_HIT, 22'h6, 0);
        lookup("R5 kernel write ro", mkva(19'h111, 7'd6, 14'h5), 1, 1, K_HIT, 22'h6, 1);
        fill(1, 0, 19'h222, 7'd7, 22'h00_0007, 2'b01, 0);
        lookup("R4 kern-only user read", mkva(19'h222, 7'd7, 14'h0), 0, 0, K_FAULT, 0, 0);
        lookup("R5 kern-only kernel read", mkva(19'h222, 7'd7, 14'h0), 0, 1, K_HIT, 22'h7, 0);
        fill(1, 0, 19'h333, 7'd8, 22'h00_0008, 2'b00, 0);
        lookup("R4 none user read", mkva(19'h333, 7'd8, 14'h0), 0, 0, K_FAULT, 0, 0);
        lookup("R4 none user write", mkva(19'h333, 7'd8, 14'h0), 1, 0, K_FAULT, 0, 0);
        lookup("R5 none kernel write", mkva(19'h333, 7'd8, 14'h0), 1, 1, K_HIT, 22'h8, 1);
    endtask

    task automatic t_user_fill();
        fill(0, 0, 19'h444, 7'd9, 22'h9, 2'b11, 0);
        lookup("R7 user install ignored", mkva(19'h444, 7'd9, 14'h0), 0, 1, K_MISS, 0, 0);
    endtask

    task automatic t_lru();
        fill(1, 0, 19'h501, 7'd10, 22'h501, 2'b11, 0);
        fill(1, 0, 19'h502, 7'd10, 22'h502, 2'b11, 0);
        lookup("R9 touch first", mkva(19'h501, 7'd10, 14'h0), 0, 0, K_HIT, 22'h501, 0);
        fill(1, 0, 19'h503, 7'd10, 22'h503, 2'b11, 0);
        lookup("R8 lru evicted", mkva(19'h502, 7'd10, 14'h0), 0, 0, K_MISS, 0, 0);
        lookup("R9 mru kept", mkva(19'h501, 7'd10, 14'h0), 0, 0, K_HIT, 22'h501, 0);
        lookup("R9 new present", mkva(19'h503, 7'd10, 14'h0), 0, 0, K_HIT, 22'h503, 0);
        fill(1, 0, 19'h504, 7'd10, 22'h504, 2'b11, 0);
        lookup("R9 order follows hits", mkva(19'h501, 7'd10, 14'h0), 0, 0, K_MISS, 0, 0);
        lookup("R9 recent kept", mkva(19'h503, 7'd10, 14'h0), 0, 0, K_HIT, 22'h503, 0);
        lookup("R9 newest kept", mkva(19'h504, 7'd10, 14'h0), 0, 0, K_HIT, 22'h504, 0);
    endtask

    task automatic t_dup();
        fill(1, 0, 19'h601, 7'd11, 22'h0AAAA, 2'b11, 0);
        fill(1, 0, 19'h601, 7'd11, 22'h0BBBB, 2'b11, 0);
        fill(1, 0, 19'h602, 7'd11, 22'h0CCCC, 2'b11, 0);
        lookup("R8 reinstall overwrote", mkva(19'h601, 7'd11, 14'h7), 0, 0, K_HIT, 22'h0BBBB, 0);
        lookup("R8 other way used", mkva(19'h602, 7'd11, 14'h7), 0, 0, K_HIT, 22'h0CCCC, 0);
    endtask

    task automatic t_inval();
        fill(1, 0, 19'h701, 7'd12, 22'h701, 2'b11, 0);
        fill(1, 0, 19'h702, 7'd12, 22'h702, 2'b11, 0);
        fill(1, 1, 19'h701, 7'd12, 0, 2'b00, 0);
        lookup("R10 removed", mkva(19'h701, 7'd12, 14'h0), 0, 1, K_MISS, 0, 0);
        lookup("R10 neighbour kept", mkva(19'h702, 7'd12, 14'h0), 0, 1, K_HIT, 22'h702, 0);
        fill(0, 1, 19'h702, 7'd12, 0, 2'b00, 0);
        lookup("R7 user invalidate ignored", mkva(19'h702, 7'd12, 14'h0), 0, 1, K_HIT, 22'h702, 0);
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup("R11 flushed a", mkva(19'h702, 7'd12, 14'h0), 0, 1, K_MISS, 0, 0);
        lookup("R11 flushed b", mkva(19'h4_1234, 7'd5, 14'h0), 0, 1, K_MISS, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; flush = 1'b0;
        req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_kernel = 1'b0;
        fill_valid = 1'b0; fill_kernel = 1'b0; fill_inval = 1'b0;
        fill_vpn = '0; fill_ppn = '0; fill_acc = '0; fill_dirty = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_perm();
        t_user_fill();
        t_lru();
        t_dup();
        t_inval();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule